// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles the single parity bit that accompanies a 32-bit multiplexed address/data bus and its four command/byte-enable lines. It sees the bus values of every clock, together with a few phase indications from the surrounding bus controller. From these it produces the parity bit this agent must place on the bus, and the enable for that driver. The parity value always follows the address/data lines one clock late. The driver is switched on only in the clock after a phase in which this agent itself owned the address/data lines: an address phase or a write data phase when acting as initiator, or a read data phase when acting as target.

In the opposite direction, the block checks parity driven by the other agent. When acting as target, it checks address phases and completed write transfers. When acting as initiator, it checks completed read transfers. The address/data and command values are captured on the transfer edge, and the received parity bit is compared one clock later. A mismatch raises a single-cycle error pulse. Idle clocks and wait states are never checked.

Top module: `pci_parity_unit`

## Requirements
- R1: Every clock after reset, `par_out` holds the XOR of all 36 bits of `ad_bus` and `cbe_bus` from the previous clock. The count of ones across those 36 bits plus `par_out` is therefore even.
- R2: As initiator (`is_master`=1), `par_oe` is 1 in the clock after an address phase (`addr_phase`=1) in which `ad_oe` was 1.
- R3: As initiator, `par_oe` is 1 in the clock after every write data-phase clock (`data_phase`=1, `is_write`=1, wait states included) in which `ad_oe` was 1.
- R4: As target (`is_master`=0), `par_oe` is 1 only in the clock after a read data-phase clock (`data_phase`=1, `is_write`=0) in which `ad_oe` was 1. It is 0 after address phases and write data phases.
- R5: `par_oe` is 0 in the clock after any clock with `ad_oe`=0, and after idle clocks (neither phase flag set).
- R6: As target, the parity of an address phase is checked. `parity_error` is 1 in the clock after the following clock if `par_in` in that following clock differs from the XOR of the captured 36 bits.
- R7: A data transfer is a data-phase clock with `irdy_n`=0 and `trdy_n`=0. Transfers are checked as in R6 when the agent is initiator on a read, or target on a write.
- R8: No check is made for wait states (`irdy_n` or `trdy_n` high), for idle clocks, or for phases this agent drove. `parity_error` stays 0 there whatever `par_in` is.
- R9: `parity_error` is a single-cycle pulse for each failing check. When back-to-back transfers fail, it is high in consecutive clocks.
- R10: While `rst_n` is low at a clock edge, `par_out`, `par_oe` and `parity_error` become 0, and any pending check is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_bus | input | 32 | Address/data value present on the bus this clock |
| cbe_bus | input | 4 | Command/byte-enable value present on the bus this clock |
| par_in | input | 1 | Parity bit sampled from the bus |
| ad_oe | input | 1 | This agent drives the address/data lines this clock |
| is_master | input | 1 | 1 when this agent is initiator of the current transaction |
| is_write | input | 1 | 1 for a write transaction, 0 for a read |
| addr_phase | input | 1 | This clock is the address phase |
| data_phase | input | 1 | This clock belongs to a data phase (transfer or wait) |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for the parity driver |
| parity_error | output | 1 | One-clock pulse on a parity mismatch |

## Verification
The bound checker watches several properties on every clock. It checks that any enabled parity output makes the previous clock's 36 bits even, and that the driver is never on without address/data ownership in the prior clock, nor after a target write. It also checks that an error pulse appears exactly when a qualifying capture is followed by a wrong parity bit. Other behaviours need the bench's scenarios: the reset values, full initiator and target transactions with wait states, deliberately corrupted parity on both directions, back-to-back error pulses, and a reset that drops a pending check.

// File: rtl/pci_par_pkg.sv
// Package: shared phase record and ownership/check decisions for the
// bus parity unit. Assumes one phase record per bus clock.
package pci_par_pkg;

    // Phase information presented by the bus controller each clock.
    typedef struct packed {
        logic addr;     // address phase clock
        logic data;     // data phase clock (transfer or wait)
        logic master;   // this agent is initiator
        logic write;    // write transaction
        logic ad_own;   // this agent drives address/data now
        logic xfer;     // both ready strobes asserted
    } phase_t;

    // Decides whether this agent must drive parity in the next clock.
    function automatic logic owns_next_par(input phase_t p);
        logic init_side;
        logic targ_side;
        init_side = p.master && (p.addr || (p.data && p.write));
        targ_side = !p.master && p.data && !p.write && !p.addr;
        return p.ad_own && (init_side || targ_side);
    endfunction

    // Decides whether the other agent's parity must be checked next clock.
    function automatic logic check_due(input phase_t p);
        logic addr_chk;
        logic data_chk;
        addr_chk = p.addr && !p.master;
        data_chk = p.data && p.xfer && (p.master ^ p.write);
        return !p.ad_own && (addr_chk || data_chk);
    endfunction

endpackage

// File: rtl/pci_par_tree.sv
// Parity reduction tree: XOR of W input bits, built as per-lane partial
// parities followed by a lane combine. Assumes W >= 1; the vector is padded
// with zeros up to a whole number of lanes. Purely combinational.
module pci_par_tree #(
    parameter int W      = 36,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    localparam int LANES = (W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] padded;
    logic [LANES-1:0] lane_par;

    // Zero-extend the input to a whole number of lanes.
    always_comb begin
        padded = '0;
        padded[W-1:0] = bits;
    end

    // One partial parity per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
    end

    // Combine the lane results.
    assign odd = ^lane_par;

endmodule

// File: rtl/pci_par_drive.sv
// Parity driver stage: registers the parity of the current bus value so it
// appears one clock late, and registers the ownership decision as the driver
// enable. Assumes synchronous active-low reset.
module pci_par_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic odd_now,
    input  logic own_next,
    output logic par_out,
    output logic par_oe
);
    // Delay parity and enable by one clock; clear both in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= odd_now;
            par_oe  <= own_next;
        end
    end
endmodule

// File: rtl/pci_par_check.sv
// Parity checker stage: captures the computed parity on a qualifying edge,
// compares it with the received bit on the following edge and pulses an
// error for one clock. Assumes synchronous active-low reset.
module pci_par_check (
    input  logic clk,
    input  logic rst_n,
    input  logic odd_now,
    input  logic due_now,
    input  logic par_in,
    output logic err
);
    logic pend_q;
    logic odd_q;

    // Hold the capture flag and captured parity for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            odd_q  <= 1'b0;
        end else begin
            pend_q <= due_now;
            odd_q  <= odd_now;
        end
    end

    // Compare the received bit against the capture; one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= pend_q && (par_in != odd_q);
        end
    end
endmodule

// File: rtl/pci_parity_unit.sv
// Top of the bus parity unit. Builds the phase record, reduces the 36 bus
// bits to one parity bit, and feeds the driver and checker stages. Assumes
// all inputs are already synchronous to clk.
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_bus,
    input  logic [CBE_W-1:0] cbe_bus,
    input  logic             par_in,
    input  logic             ad_oe,
    input  logic             is_master,
    input  logic             is_write,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             irdy_n,
    input  logic             trdy_n,
    output logic             par_out,
    output logic             par_oe,
    output logic             parity_error
);
    localparam int TOT_W = AD_W + CBE_W;

    phase_t     ph;
    logic       odd_now;
    logic       own_next;
    logic       due_now;

    // Assemble this clock's phase record.
    always_comb begin
        ph.addr   = addr_phase;
        ph.data   = data_phase;
        ph.master = is_master;
        ph.write  = is_write;
        ph.ad_own = ad_oe;
        ph.xfer   = !irdy_n && !trdy_n;
    end

    // Decide driver ownership and checking for the next clock.
    always_comb begin
        own_next = owns_next_par(ph);
        due_now  = check_due(ph);
    end

    pci_par_tree #(.W(TOT_W), .LANE_W(8)) u_tree (
        .bits ({ad_bus, cbe_bus}),
        .odd  (odd_now)
    );

    pci_par_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .odd_now  (odd_now),
        .own_next (own_next),
        .par_out  (par_out),
        .par_oe   (par_oe)
    );

    pci_par_check u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .odd_now (odd_now),
        .due_now (due_now),
        .par_in  (par_in),
        .err     (parity_error)
    );

endmodule

// File: rtl/pci_parity_unit_chk.sv
// Checker for the bus parity unit, bound to every instance. Relates the
// outputs to the port values of the previous clock.
module pci_parity_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ad_bus,
    input logic [3:0]  cbe_bus,
    input logic        par_in,
    input logic        ad_oe,
    input logic        is_master,
    input logic        is_write,
    input logic        addr_phase,
    input logic        data_phase,
    input logic        irdy_n,
    input logic        trdy_n,
    input logic        par_out,
    input logic        par_oe,
    input logic        parity_error
);
    logic qual;
    assign qual = !ad_oe && ((addr_phase && !is_master) ||
                  (data_phase && !irdy_n && !trdy_n &&
                   ((is_master && !is_write) || (!is_master && is_write))));

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (($countones({$past(ad_bus), $past(cbe_bus)}) + 32'(par_out)) % 2 == 0)); // R1

    AST_OE_NEEDS_AD: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(ad_oe)); // R5

    AST_NO_OE_TGT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!is_master && is_write) && $past(rst_n)) |-> !par_oe); // R4

    AST_ERR_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        qual ##1 (rst_n && (par_in != ^{$past(ad_bus), $past(cbe_bus)})) |=> parity_error); // R7

    AST_ERR_ONLY_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |-> $past(qual, 2)); // R8

endmodule

bind pci_parity_unit pci_parity_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_bus       (ad_bus),
    .cbe_bus      (cbe_bus),
    .par_in       (par_in),
    .ad_oe        (ad_oe),
    .is_master    (is_master),
    .is_write     (is_write),
    .addr_phase   (addr_phase),
    .data_phase   (data_phase),
    .irdy_n       (irdy_n),
    .trdy_n       (trdy_n),
    .par_out      (par_out),
    .par_oe       (par_oe),
    .parity_error (parity_error)
);

// File: tb/pci_parity_unit_test.sv
// Scoreboard bench: the driver task applies one clock of stimulus and pushes
// the outputs expected after that clock; the monitor pops and compares.
module pci_parity_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_bus = '0;
    logic [3:0]  cbe_bus = '0;
    logic        par_in = 1'b0;
    logic        ad_oe = 1'b0;
    logic        is_master = 1'b0;
    logic        is_write = 1'b0;
    logic        addr_phase = 1'b0;
    logic        data_phase = 1'b0;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        par_out;
    logic        par_oe;
    logic        parity_error;

    typedef struct {
        logic  par;
        logic  oe;
        logic  err;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic m_pend   = 1'b0;
    logic m_par    = 1'b0;
    logic done     = 1'b0;

    always #2 clk = ~clk;

    pci_parity_unit uut (
        .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cbe_bus(cbe_bus),
        .par_in(par_in), .ad_oe(ad_oe), .is_master(is_master),
        .is_write(is_write), .addr_phase(addr_phase), .data_phase(data_phase),
        .irdy_n(irdy_n), .trdy_n(trdy_n), .par_out(par_out), .par_oe(par_oe),
        .parity_error(parity_error)
    );

    // Drive one clock of stimulus and queue the expected outputs.
    task automatic step(input string tag, input logic rst, input logic [31:0] ad,
                        input logic [3:0] cbe, input logic pin, input logic oe,
                        input logic m, input logic w, input logic a, input logic d,
                        input logic ir, input logic tr);
        exp_t e;
        logic odd;
        logic own;
        logic chk;
        @(negedge clk);
        rst_n = rst; ad_bus = ad; cbe_bus = cbe; par_in = pin; ad_oe = oe;
        is_master = m; is_write = w; addr_phase = a; data_phase = d;
        irdy_n = ir; trdy_n = tr;
        odd = ^{ad, cbe};
        own = oe && ((m && (a || (d && w))) || (!m && d && !w && !a));
        chk = !oe && ((a && !m) || (d && !ir && !tr && (m != w)));
        e.tag = tag;
        if (!rst) begin
            e.par = 1'b0; e.oe = 1'b0; e.err = 1'b0;
            m_pend = 1'b0; m_par = 1'b0;
        end else begin
            e.par = odd; e.oe = own; e.err = m_pend && (pin != m_par);
            m_pend = chk; m_par = odd;
        end
        exp_q.push_back(e);
    endtask

    // Compare outputs shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (par_out !== e.par || par_oe !== e.oe || parity_error !== e.err) begin
                n_fail++;
                $display("FAIL %s: got par=%b oe=%b err=%b expected par=%b oe=%b err=%b",
                         e.tag, par_out, par_oe, parity_error, e.par, e.oe, e.err);
            end
        end
    end

    function automatic logic ep(input logic [31:0] ad, input logic [3:0] cbe);
        return ^{ad, cbe};
    endfunction

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step("R10 reset", 0, 32'hFFFF_FFFF, 4'hF, 1, 1, 1, 1, 1, 0, 0, 0);
        step("R10 reset", 0, 32'h1234_5678, 4'h3, 0, 1, 1, 1, 1, 0, 0, 0);
        // R2 / R1: initiator address phase, then write data with waits (R3)
        step("R2 addr", 1, 32'h8000_0001, 4'h7, 0, 1, 1, 1, 1, 0, 1, 1);
        step("R3 wait", 1, 32'hDEAD_BEEF, 4'h0, 0, 1, 1, 1, 0, 1, 0, 1);
        step("R3 xfer", 1, 32'hDEAD_BEEF, 4'h0, 0, 1, 1, 1, 0, 1, 0, 0);
        step("R1 xfer", 1, 32'h0000_0003, 4'h1, 1, 1, 1, 1, 0, 1, 0, 0);
        // R5: idle with bad parity, no enable and no error (R8)
        step("R5 idle", 1, 32'h0F0F_0F0F, 4'h5, 1, 0, 0, 0, 0, 0, 1, 1);
        step("R8 idle", 1, 32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 1);
        // R6: target address phase, good then bad parity
        step("R6 addr", 1, 32'hA5A5_0001, 4'h6, 0, 0, 0, 0, 1, 0, 1, 1);
        step("R6 good", 1, 32'h0, 4'h0, ep(32'hA5A5_0001, 4'h6), 0, 0, 0, 0, 1, 1, 1);
        step("R6 addr", 1, 32'hA5A5_0003, 4'h6, 0, 0, 0, 0, 1, 0, 1, 1);
        step("R6 bad", 1, 32'h0, 4'h0, ~ep(32'hA5A5_0003, 4'h6), 0, 0, 0, 0, 1, 1, 1);
        step("R9 pulse", 1, 32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 1);
        // R4: target read data with wait; drives parity
        step("R4 wait", 1, 32'h1111_2222, 4'h0, 0, 1, 0, 0, 0, 1, 1, 0);
        step("R4 xfer", 1, 32'h1111_2223, 4'h0, 0, 1, 0, 0, 0, 1, 0, 0);
        // R4: target never drives for address or write phases
        step("R4 taddr", 1, 32'h4, 4'h2, 0, 1, 0, 1, 1, 0, 1, 1);
        step("R4 twr", 1, 32'h5, 4'hF, 0, 1, 0, 1, 0, 1, 0, 0);
        // R7: target write transfers, back-to-back bad (R9)
        step("R7 twr", 1, 32'hCAFE_0000, 4'h0, 0, 0, 0, 1, 0, 1, 0, 0);
        step("R7 twr", 1, 32'hCAFE_0001, 4'h0, ~ep(32'hCAFE_0000, 4'h0), 0, 0, 1, 0, 1, 0, 0);
        step("R9 b2b", 1, 32'h0, 4'h0, ~ep(32'hCAFE_0001, 4'h0), 0, 0, 1, 0, 1, 1, 1);
        step("R9 b2b", 1, 32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R8: target write wait states with bad parity, no error
        step("R8 wait", 1, 32'h77, 4'h0, 0, 0, 0, 1, 0, 1, 1, 0);
        step("R8 wait", 1, 32'h77, 4'h0, 1, 0, 0, 1, 0, 1, 0, 1);
        step("R8 wait", 1, 32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 1);
        // R7: initiator read transfer, bad parity
        step("R7 mrd", 1, 32'h0000_0100, 4'h0, 0, 0, 1, 0, 0, 1, 0, 0);
        step("R7 mrd", 1, 32'h0, 4'h0, ~ep(32'h0000_0100, 4'h0), 0, 1, 0, 0, 1, 1, 1);
        step("R7 mrd", 1, 32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R8: initiator write transfer is not checked
        step("R8 mwr", 1, 32'h9, 4'h0, 0, 0, 1, 1, 0, 1, 0, 0);
        step("R8 mwr", 1, 32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 1);
        step("R8 mwr", 1, 32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R10: reset drops a pending check
        step("R10 pend", 1, 32'h3, 4'h0, 0, 0, 0, 0, 1, 0, 1, 1);
        step("R10 drop", 0, 32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R10 drop", 1, 32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 1);
        step("R10 tail", 1, 32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule